// File: doc/BRIEF.md
# Per-Channel Tristate Control Generator

This block drives sixteen control lines, one for each serial output stream of a time-division multiplexed bus. Each line tells an external bus driver when to turn off its output. A high level means "high impedance". The frame is always 8192 master-clock periods long. It is split into 32, 64 or 128 equal channel slots, depending on the selected output rate. A control line follows the channel timing of its own stream, so it is high for exactly the slots that software has marked as high impedance.

Software writes the marks one bit at a time through an address/data/write-enable port. The bits go into a shadow mask. The shadow mask is copied into the active mask at each frame pulse, so a frame is never changed partway through. Each stream has its own programmed output delay: a channel delay, a bit delay and a quarter-bit advance. The control line tracks that delay. It can then be moved earlier by zero to four extra steps, where one step is either a single master clock or a quarter of a data bit.

Three conditions force every affected line high, whatever the mask says: a low output-enable, an asserted reset, or a stream that is marked unused. Internally a two-state machine stays in `WAIT` (all lines high) from reset until the first frame pulse. The transition `LOCK` then moves it to `RUN`, where it stays and where each frame pulse realigns the position counter.

Top module: `hz_ctrl_gen`

## Requirements
- R1: An active-low reset (asynchronous) forces all sixteen outputs high at once. After reset is released, the outputs stay high until the first frame pulse is sampled.
- R2: The clock edge that samples `fp_i` high is frame position 0. Each later edge adds one to the position, modulo 8192. The registered outputs show the position of the edge that last updated them.
- R3: `rate_i` selects the slot length. The value 0 gives 32 slots of 256 clocks each. The value 1 gives 64 slots of 128 clocks. The value 2 gives 128 slots of 64 clocks. The value 3 behaves like 2.
- R4: For an enabled stream with no delay or advance, the output is high for the whole slot whose mask bit is 1, and low for the whole slot whose mask bit is 0.
- R5: While `oe_i` is low, every output is high in that same cycle, with no clock edge needed.
- R6: A stream whose `strm_en_i` bit is 0 has its output high in every cycle of the frame.
- R7: Per stream, the slot window is moved later by `ch_dly_i` slots plus `bit_dly_i` bit times (one bit is one eighth of a slot). It is moved earlier by `frac_adv_i` quarter-bits. All of this wraps modulo 8192.
- R8: `adv_steps_i` moves every window earlier by 0 to 4 steps. The values 5 to 7 act as 4. With 0 steps the output changes on the same edge as the stream's slot boundary.
- R9: When `adv_qbit_i` is 0, one step is one master clock. When it is 1, one step is a quarter of a bit: 8, 4 or 2 clocks for rate 0, 1 or 2.
- R10: A write to mask bit (`wr_strm_i`, `wr_ch_i`) takes effect at the next frame pulse. A write sampled on the same edge as a frame pulse waits for the pulse after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high for one clock at position 0 |
| oe_i | input | 1 | Output enable; low forces all outputs high |
| rate_i | input | 2 | Rate select (slot length) |
| strm_en_i | input | 16 | Per-stream in-use bits |
| ch_dly_i | input | 16x7 | Per-stream channel delay |
| bit_dly_i | input | 16x3 | Per-stream bit delay |
| frac_adv_i | input | 16x2 | Per-stream quarter-bit advance |
| adv_steps_i | input | 3 | Extra advance step count |
| adv_qbit_i | input | 1 | Step size: 0 one clock, 1 quarter bit |
| wr_en_i | input | 1 | Mask write strobe |
| wr_strm_i | input | 4 | Mask write stream index |
| wr_ch_i | input | 7 | Mask write channel index |
| wr_bit_i | input | 1 | Mask write value (1 = high impedance) |
| hz_o | output | 16 | Per-stream high-impedance control |

## Verification
If the position counter slips or is realigned wrongly, every enabled stream's pulse edges shift by the same number of clocks, and the first slot boundary after the frame pulse shows it. A mistake in the active mask, or a copy from the shadow mask at the wrong time, shows up as a pulse in the wrong slot. It appears in the frame where a mid-frame write or a write on the pulse edge would otherwise stay hidden. If the machine stays in the wrong state, the lines are either still high after the first pulse or already low before it, and this is visible from the first edge.

// File: rtl/hz_ctrl_pkg.sv
package hz_ctrl_pkg;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } fsm_e;

    // log2 of the slot length in master clocks for a rate code
    function automatic logic [3:0] slot_shift(input logic [1:0] rate);
        unique case (rate)
            2'd0:    return 4'd8;
            2'd1:    return 4'd7;
            default: return 4'd6;
        endcase
    endfunction

endpackage

// File: rtl/hz_frame_fsm.sv
module hz_frame_fsm
    import hz_ctrl_pkg::*;
#(
    parameter int FRAME_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fp_i,
    output fsm_e               state_o,
    output logic [FRAME_W-1:0] cnt_o,
    output logic [FRAME_W-1:0] pos_n_o,
    output logic               run_n_o
);

    fsm_e               state_q, state_d;
    logic [FRAME_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // LOCK: WAIT -> RUN on the first frame pulse; RUN holds and realigns
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + FRAME_W'(1);
        unique case (state_q)
            ST_WAIT: begin
                cnt_d = '0;
                if (fp_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (fp_i) cnt_d = '0;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign pos_n_o = cnt_d;
    assign run_n_o = (state_d == ST_RUN);

endmodule

// File: rtl/hz_lane_pos.sv
module hz_lane_pos #(
    parameter int FRAME_W = 13,
    parameter int CH_W    = 7
) (
    input  logic [FRAME_W-1:0] pos_i,
    input  logic [3:0]         slot_sh_i,
    input  logic [CH_W-1:0]    ch_dly_i,
    input  logic [2:0]         bit_dly_i,
    input  logic [1:0]         frac_i,
    input  logic [2:0]         adv_i,
    input  logic               adv_qbit_i,
    output logic [CH_W-1:0]    ch_o
);

    logic [3:0]         bit_sh, q_sh;
    logic [2:0]         steps;
    logic [FRAME_W-1:0] d_ch, d_bit, d_frac, a_amt, rel;

    always_comb begin
        bit_sh = slot_sh_i - 4'd3;
        q_sh   = slot_sh_i - 4'd5;
        steps  = (adv_i > 3'd4) ? 3'd4 : adv_i;
        d_ch   = FRAME_W'({{FRAME_W{1'b0}}, ch_dly_i} << slot_sh_i);
        d_bit  = FRAME_W'({{FRAME_W{1'b0}}, bit_dly_i} << bit_sh);
        d_frac = FRAME_W'({{FRAME_W{1'b0}}, frac_i} << q_sh);
        a_amt  = adv_qbit_i ? FRAME_W'({{FRAME_W{1'b0}}, steps} << q_sh)
                            : FRAME_W'(steps);
        rel    = pos_i - d_ch - d_bit + d_frac + a_amt;
        ch_o   = CH_W'(rel >> slot_sh_i);
    end

endmodule

// File: rtl/hz_mask_bank.sv
module hz_mask_bank #(
    parameter int NSTRM = 16,
    parameter int NCH   = 128,
    localparam int CH_W = $clog2(NCH),
    localparam int SW   = $clog2(NSTRM)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       swap_i,
    input  logic                       wr_en_i,
    input  logic [SW-1:0]              wr_strm_i,
    input  logic [CH_W-1:0]            wr_ch_i,
    input  logic                       wr_bit_i,
    input  logic [NSTRM-1:0][CH_W-1:0] ch_idx_i,
    output logic [NSTRM-1:0]           hit_o
);

    logic [NSTRM-1:0][NCH-1:0] shadow_q, active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en_i) shadow_q[wr_strm_i][wr_ch_i] <= wr_bit_i;
            if (swap_i)  active_q <= shadow_q;
        end
    end

    // on the boundary edge the incoming frame already reads the new copy
    for (genvar s = 0; s < NSTRM; s++) begin : g_look
        assign hit_o[s] = swap_i ? shadow_q[s][ch_idx_i[s]]
                                 : active_q[s][ch_idx_i[s]];
    end

endmodule

// File: rtl/hz_ctrl_gen.sv
module hz_ctrl_gen
    import hz_ctrl_pkg::*;
#(
    parameter int NSTRM   = 16,
    parameter int NCH     = 128,
    parameter int FRAME_W = 13,
    localparam int CH_W   = $clog2(NCH),
    localparam int SW     = $clog2(NSTRM)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fp_i,
    input  logic                       oe_i,
    input  logic [1:0]                 rate_i,
    input  logic [NSTRM-1:0]           strm_en_i,
    input  logic [NSTRM-1:0][CH_W-1:0] ch_dly_i,
    input  logic [NSTRM-1:0][2:0]      bit_dly_i,
    input  logic [NSTRM-1:0][1:0]      frac_adv_i,
    input  logic [2:0]                 adv_steps_i,
    input  logic                       adv_qbit_i,
    input  logic                       wr_en_i,
    input  logic [SW-1:0]              wr_strm_i,
    input  logic [CH_W-1:0]            wr_ch_i,
    input  logic                       wr_bit_i,
    output logic [NSTRM-1:0]           hz_o
);

    fsm_e                       state_w;
    logic [FRAME_W-1:0]         cnt_w, pos_n;
    logic                       run_n;
    logic [3:0]                 slot_sh;
    logic [NSTRM-1:0][CH_W-1:0] ch_idx;
    logic [NSTRM-1:0]           hit, hz_d, hz_q;

    assign slot_sh = slot_shift(rate_i);

    hz_frame_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fp_i    (fp_i),
        .state_o (state_w),
        .cnt_o   (cnt_w),
        .pos_n_o (pos_n),
        .run_n_o (run_n)
    );

    for (genvar s = 0; s < NSTRM; s++) begin : g_lane
        hz_lane_pos #(.FRAME_W(FRAME_W), .CH_W(CH_W)) u_pos (
            .pos_i      (pos_n),
            .slot_sh_i  (slot_sh),
            .ch_dly_i   (ch_dly_i[s]),
            .bit_dly_i  (bit_dly_i[s]),
            .frac_i     (frac_adv_i[s]),
            .adv_i      (adv_steps_i),
            .adv_qbit_i (adv_qbit_i),
            .ch_o       (ch_idx[s])
        );
    end

    hz_mask_bank #(.NSTRM(NSTRM), .NCH(NCH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_i    (fp_i),
        .wr_en_i   (wr_en_i),
        .wr_strm_i (wr_strm_i),
        .wr_ch_i   (wr_ch_i),
        .wr_bit_i  (wr_bit_i),
        .ch_idx_i  (ch_idx),
        .hit_o     (hit)
    );

    assign hz_d = ~({NSTRM{run_n}} & strm_en_i & ~hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hz_q <= '1;
        else        hz_q <= hz_d;
    end

    assign hz_o = hz_q | {NSTRM{~oe_i}};

endmodule

// File: rtl/hz_ctrl_gen_chk.sv
module hz_ctrl_gen_chk
    import hz_ctrl_pkg::*;
#(
    parameter int NSTRM   = 16,
    parameter int FRAME_W = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fp_i,
    input logic               oe_i,
    input logic [NSTRM-1:0]   strm_en_i,
    input logic [NSTRM-1:0]   hz_o,
    input fsm_e               state,
    input logic [FRAME_W-1:0] cnt
);

    assert_wait_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (&hz_o));

    assert_pulse_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> (cnt == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !fp_i) |=> (cnt == FRAME_W'($past(cnt) + FRAME_W'(1))));

    assert_oe_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> (&hz_o));

    assert_unused_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (&(hz_o | $past(strm_en_i))));

endmodule

bind hz_ctrl_gen hz_ctrl_gen_chk #(.NSTRM(NSTRM), .FRAME_W(FRAME_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fp_i      (fp_i),
    .oe_i      (oe_i),
    .strm_en_i (strm_en_i),
    .hz_o      (hz_o),
    .state     (state_w),
    .cnt       (cnt_w)
);

// File: tb/hz_ctrl_gen_tb.sv
module hz_ctrl_gen_tb;

    localparam int NS    = 16;
    localparam int NC    = 128;
    localparam int FRAME = 8192;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                fp = 1'b0;
    logic                oe = 1'b1;
    logic [1:0]          rate = 2'd0;
    logic [NS-1:0]       en = '1;
    logic [NS-1:0][6:0]  chd = '0;
    logic [NS-1:0][2:0]  bd = '0;
    logic [NS-1:0][1:0]  fr = '0;
    logic [2:0]          adv = 3'd0;
    logic                qb = 1'b0;
    logic                wr_en = 1'b0;
    logic [3:0]          wr_s = '0;
    logic [6:0]          wr_c = '0;
    logic                wr_b = 1'b0;
    logic [NS-1:0]       hz;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  mdl [NS][NC];

    logic [NS-1:0] exp_q [$];
    string         tag_q [$];

    always #5 clk = ~clk;

    hz_ctrl_gen u_dut (
        .clk(clk), .rst_n(rst_n), .fp_i(fp), .oe_i(oe), .rate_i(rate),
        .strm_en_i(en), .ch_dly_i(chd), .bit_dly_i(bd), .frac_adv_i(fr),
        .adv_steps_i(adv), .adv_qbit_i(qb), .wr_en_i(wr_en), .wr_strm_i(wr_s),
        .wr_ch_i(wr_c), .wr_bit_i(wr_b), .hz_o(hz)
    );

    task automatic check(input logic [NS-1:0] act, input logic [NS-1:0] exv, input string tag);
        checks++;
        if (act !== exv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exv);
        end
    endtask

    // expected value from the requirements: slot length, delays, clamp, step size
    function automatic logic [NS-1:0] exp_vec(input int n, input bit oe_now);
        logic [NS-1:0] v;
        int slot, off, p, stp;
        slot = (rate == 2'd0) ? 256 : (rate == 2'd1) ? 128 : 64;
        stp  = (adv > 3'd4) ? 4 : int'(adv);
        for (int s = 0; s < NS; s++) begin
            if (!oe_now || !en[s]) v[s] = 1'b1;
            else begin
                off = int'(chd[s]) * slot + int'(bd[s]) * (slot / 8)
                    - int'(fr[s]) * (slot / 32) - stp * (qb ? slot / 32 : 1);
                p = (((n - off) % FRAME) + FRAME) % FRAME;
                v[s] = mdl[s][p / slot];
            end
        end
        return v;
    endfunction

    // monitor: pops one expected item per edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [NS-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(hz, e, t);
        end
    end

    // driver: one full frame, starting at a falling edge
    task automatic run_frame(input string tag, input int wr_at, input int ws, input int wc,
                             input bit wb, input int oe_a, input int oe_b);
        fp = 1'b1;
        for (int n = 0; n < FRAME; n++) begin
            exp_q.push_back(exp_vec(n, !(n >= oe_a && n < oe_b)));
            tag_q.push_back(tag);
        end
        if (wr_at == 0) begin
            wr_en = 1'b1; wr_s = 4'(ws); wr_c = 7'(wc); wr_b = wb;
        end
        for (int i = 1; i <= FRAME; i++) begin
            @(negedge clk);
            if (i == 1) fp = 1'b0;
            if (i == wr_at + 1) wr_en = 1'b0;
            if (i == wr_at && wr_at > 0) begin
                wr_en = 1'b1; wr_s = 4'(ws); wr_c = 7'(wc); wr_b = wb;
            end
            if (i == oe_a) oe = 1'b0;
            if (i == oe_b) oe = 1'b1;
        end
        if (wr_at >= 0) mdl[ws][wc] = wb;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(hz, '1, "R1 during reset");
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(hz, '1, "R1 before first frame pulse");
        end
        // initial mask fill, all effective at the first pulse (R10)
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < NC; c++) begin
                @(negedge clk);
                mdl[s][c] = ((s * 5 + c * 3) % 7 == 0) || (c == s);
                wr_en = 1'b1; wr_s = 4'(s); wr_c = 7'(c); wr_b = mdl[s][c];
            end
        end
        @(negedge clk);
        wr_en = 1'b0;

        run_frame("R2 R3 R4 rate0 plain", -1, 0, 0, 1'b0, -1, -1);

        rate = 2'd1; en[5] = 1'b0; en[12] = 1'b0;
        for (int s = 0; s < NS; s++) begin
            chd[s] = 7'((s * 9) % 128); bd[s] = 3'(s % 8); fr[s] = 2'((s * 3) % 4);
        end
        run_frame("R3 R6 R7 rate1 delays", -1, 0, 0, 1'b0, -1, -1);

        rate = 2'd2; adv = 3'd3; qb = 1'b0; en = '1;
        run_frame("R7 R8 R9 clock steps", -1, 0, 0, 1'b0, -1, -1);

        adv = 3'd7; qb = 1'b1;
        run_frame("R8 R9 clamped quarter-bit steps", -1, 0, 0, 1'b0, -1, -1);

        rate = 2'd0; adv = 3'd2; chd = '0; bd = '0; fr = '0;
        run_frame("R10 mid-frame write held", 300, 2, 3, ~mdl[2][3], -1, -1);
        run_frame("R10 write on pulse edge held", 0, 9, 10, ~mdl[9][10], -1, -1);
        run_frame("R5 R10 oe window", -1, 0, 0, 1'b0, 1000, 2000);

        rate = 2'd3; adv = 3'd0;
        run_frame("R3 rate code 3", -1, 0, 0, 1'b0, -1, -1);

        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(hz, '1, "R1 asynchronous reset");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule